// File: doc/BRIEF.md
# Interrupt cause, mask and throttle unit

This block keeps the interrupt state of a network controller. Individual event sources raise cause bits 30:0 by pulsing an event input. Software reads and acknowledges them through a small 32-bit register port. The block drives a single level interrupt line, which is the cause register's bit 31 (the asserted flag).

A throttle timer can hold back assertion by a programmable interval, counted in 256 ns units. Whether a new cause asserts the line at once or arms the timer depends on the interval, on an "immediate" qualifier carried with the event, and on whether an enabled cause is already pending.

The register port selects one of six registers with a 3-bit code:

| Code | Register | Access |
|------|----------|--------|
| 0 | cause | read-to-clear, write-1-to-clear |
| 1 | set-cause | write only |
| 2 | mask-set | write, and reads back the mask |
| 3 | mask-clear | write only |
| 4 | auto-mask | read/write |
| 5 | interval | read/write |

Software acknowledges a cause by reading or writing the cause register. On that acknowledge, an optional auto-mask step removes chosen bits from the mask.

Events and register accesses are handled in a fixed order within a clock cycle, so that simultaneous activity has a single defined result.

Top module: `irq_moderator`

## Requirements
- R1: After reset, the interrupt output is low, and the cause, mask, auto-mask and interval registers all read zero. Read data appears on `acc_rdata` one clock after a read with `acc_en`=1 and `acc_we`=0. Register codes are: 0 cause, 1 set-cause, 2 mask-set (reads back the mask), 3 mask-clear, 4 auto-mask, 5 interval. Codes 1, 3, 6 and 7 read zero.
- R2: Register contents and read format:
  - The interval register holds `wdata[ITV_W-1:0]`.
  - The auto-mask register holds `wdata[30:0]`.
  - Mask and auto-mask bit 31 always read 0.
  - A cause read returns {asserted flag, cause[30:0]}, with the flag at bit 31.
- R3: An event is taken as new when at least one of its bits is 1 and none of them is already set in the cause register. A new event that finds no enabled cause pending (cause AND mask = 0) is ORed into the cause bits. If the interval is zero, or `evt_now` is 1, the event then cancels any running timer and sets the flag; `irq` is high after that edge.
- R4: Otherwise the new event starts (or reloads) the throttle timer. The flag then sets exactly interval×`TPU` clocks after the edge that took the event. A timer that is cancelled before it expires never sets the flag.
- R5: An event with any bit already set in the cause register is ignored entirely: the cause bits, mask, flag and timer are all unchanged.
- R6: A new event that finds an enabled cause pending is ORed in. It then:
  - starts the timer only if the timer is not running;
  - leaves a running timer's expiry time unchanged;
  - sets the flag at once instead of starting the timer when the interval is zero.
- R7: A cause read clears bits 29:0 only when the flag was set, or when the mask is zero. Bit 30 is never cleared by a read. The read is then followed by re-evaluation.
- R8: With `am_enable`=1, a cause read taken while the flag is set applies mask &= ~auto-mask.
- R9: A cause write clears the cause bits written as 1 in `wdata[30:0]`. With `am_enable`=1, it also applies mask &= ~auto-mask. Re-evaluation follows.
- R10: A mask-set write ORs `wdata[30:0]` into the mask, and a mask-clear write ANDs the mask with the inverse of `wdata[30:0]`. Re-evaluation then works as follows:
  - with no enabled cause pending, it cancels the timer and clears the flag;
  - with an enabled cause pending and a zero interval, it sets the flag;
  - with an enabled cause pending and a nonzero interval, it starts the timer if the timer is idle.
- R11: A set-cause write posts `wdata[30:0]` as a non-immediate event under the rules of R3 to R6.
- R12: In one cycle, the register access is applied first. The event is applied next, using the updated interval and mask. The timer is counted last. A timer started or cancelled in that cycle does not count, and a read returns the register values from before the cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Register access strobe |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 3 | Register code |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Registered read data |
| am_enable | input | 1 | Enables auto-masking on acknowledge |
| evt_valid | input | 1 | Event strobe |
| evt_bits | input | 31 | Cause bits carried by the event |
| evt_now | input | 1 | Event bypasses the throttle when no enabled cause is pending |
| irq | output | 1 | Level interrupt output (asserted flag) |

## Verification
The hardest situation to reach is one where the throttle timer is already running when a second, enabled cause arrives, because the second event must not move the expiry. The stimulus arms the timer with one masked-in cause, waits part of the interval, and then posts a second enabled cause. The reference model then demands that the line rises on the first event's schedule. The stimulus also cancels a running timer through a mask-clear to show that no late assertion leaks out. Same-cycle collisions are driven on purpose: an interval write together with an event, and a cause read together with an event.

// File: rtl/irqm_pkg.sv
package irqm_pkg;

  localparam int CAUSE_W = 31;

  typedef enum logic [2:0] {
    SEL_CAUSE = 3'd0,
    SEL_SETC  = 3'd1,
    SEL_MSET  = 3'd2,
    SEL_MCLR  = 3'd3,
    SEL_AMASK = 3'd4,
    SEL_ITV   = 3'd5
  } reg_sel_e;

  typedef struct packed {
    logic [CAUSE_W-1:0] cause;
    logic               flag;
    logic [CAUSE_W-1:0] mask;
    logic               run;
    logic               start;
    logic               cancel;
  } irq_st_t;

  // Re-evaluate interrupt state after a mask or cause change.
  function automatic irq_st_t f_reeval(irq_st_t s, logic itv_zero);
    irq_st_t r;
    r = s;
    if ((r.cause & r.mask) == '0) begin
      r.run    = 1'b0;
      r.start  = 1'b0;
      r.cancel = 1'b1;
      r.flag   = 1'b0;
    end else if (itv_zero) begin
      r.flag = 1'b1;
    end else if (!r.run) begin
      r.run   = 1'b1;
      r.start = 1'b1;
    end
    return r;
  endfunction

  // Post a set of causes as an event.
  function automatic irq_st_t f_post(irq_st_t s, logic [CAUSE_W-1:0] t,
                                     logic now, logic itv_zero);
    irq_st_t r;
    r = s;
    if (t != '0 && (t & r.cause) == '0) begin
      if ((r.cause & r.mask) != '0) begin
        r.cause = r.cause | t;
        if (!r.run) begin
          if (itv_zero) r.flag = 1'b1;
          else begin
            r.run   = 1'b1;
            r.start = 1'b1;
          end
        end
      end else begin
        r.cause = r.cause | t;
        if (itv_zero || now) begin
          r.run    = 1'b0;
          r.start  = 1'b0;
          r.cancel = 1'b1;
          r.flag   = 1'b1;
        end else begin
          r.run   = 1'b1;
          r.start = 1'b1;
        end
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/irqm_timer.sv
module irqm_timer #(
  parameter int ITV_W = 16,
  parameter int TPU   = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cancel,
  input  logic [ITV_W-1:0] units,
  output logic             running,
  output logic             fire
);
  localparam int CNT_W = ITV_W + $clog2(TPU) + 1;
  localparam logic [CNT_W-1:0] TPU_C = CNT_W'(TPU);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic [CNT_W-1:0] load_v;

  assign load_v  = CNT_W'(units) * TPU_C;
  assign running = run_q;
  assign fire    = run_q && (cnt_q == CNT_W'(1)) && !start && !cancel;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      cnt_q <= load_v;
    end else if (cancel) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      if (cnt_q == CNT_W'(1)) run_q <= 1'b0;
      else cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R4: an expiry leaves the timer idle
  a_r4_fire_stops: assert property (@(posedge clk) disable iff (rst)
    fire |=> !running);

endmodule

// File: rtl/irqm_core.sv
module irqm_core
  import irqm_pkg::*;
#(
  parameter int ITV_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               acc_en,
  input  logic               acc_we,
  input  logic [2:0]         acc_sel,
  input  logic [CAUSE_W-1:0] wdata,
  input  logic               am_enable,
  input  logic               evt_valid,
  input  logic [CAUSE_W-1:0] evt_bits,
  input  logic               evt_now,
  input  logic               t_run,
  input  logic               t_fire,
  output logic               t_start,
  output logic               t_cancel,
  output logic [ITV_W-1:0]   t_units,
  output logic [CAUSE_W-1:0] cause_q,
  output logic               flag_q,
  output logic [CAUSE_W-1:0] mask_q,
  output logic [CAUSE_W-1:0] am_q,
  output logic [ITV_W-1:0]   itv_q
);
  irq_st_t            s;
  logic [ITV_W-1:0]   itv_n;
  logic [CAUSE_W-1:0] am_n;

  always_comb begin
    s        = '0;
    s.cause  = cause_q;
    s.flag   = flag_q;
    s.mask   = mask_q;
    s.run    = t_run;
    itv_n    = itv_q;
    am_n     = am_q;
    if (acc_en && acc_we) begin
      case (acc_sel)
        SEL_CAUSE: begin
          if (am_enable) s.mask = s.mask & ~am_q;
          s.cause = s.cause & ~wdata;
          s = f_reeval(s, itv_q == '0);
        end
        SEL_SETC: s = f_post(s, wdata, 1'b0, itv_q == '0);
        SEL_MSET: begin
          s.mask = s.mask | wdata;
          s = f_reeval(s, itv_q == '0);
        end
        SEL_MCLR: begin
          s.mask = s.mask & ~wdata;
          s = f_reeval(s, itv_q == '0);
        end
        SEL_AMASK: am_n = wdata;
        SEL_ITV:   itv_n = wdata[ITV_W-1:0];
        default: ;
      endcase
    end else if (acc_en && acc_sel == SEL_CAUSE) begin
      if (flag_q || mask_q == '0) s.cause[29:0] = '0;
      if (am_enable && flag_q) s.mask = s.mask & ~am_q;
      s = f_reeval(s, itv_q == '0);
    end
    if (evt_valid) s = f_post(s, evt_bits, evt_now, itv_n == '0);
  end

  assign t_start  = s.start;
  assign t_cancel = s.cancel;
  assign t_units  = itv_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      flag_q  <= 1'b0;
      mask_q  <= '0;
      am_q    <= '0;
      itv_q   <= '0;
    end else begin
      cause_q <= s.cause;
      flag_q  <= s.flag | t_fire;
      mask_q  <= s.mask;
      am_q    <= am_n;
      itv_q   <= itv_n;
    end
  end

  // R10: clearing every mask bit with no event deasserts
  a_r10_clear_all: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_we && acc_sel == SEL_MCLR && wdata == '1 && !evt_valid)
    |=> !flag_q);

  // R7: a cause read while asserted clears the low cause bits
  a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !acc_we && acc_sel == SEL_CAUSE && flag_q && !evt_valid)
    |=> cause_q[29:0] == '0);

  // R5: an overlapping event leaves the state alone
  a_r5_dup_ignored: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && (evt_bits & cause_q) != '0 && !acc_en)
    |=> ($stable(cause_q) && $stable(mask_q)));

  // R3: immediate new event with nothing enabled pending asserts
  a_r3_immediate: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_now && evt_bits != '0 && (evt_bits & cause_q) == '0 &&
     (cause_q & mask_q) == '0 && !acc_en) |=> flag_q);

endmodule

// File: rtl/irqm_rdmux.sv
module irqm_rdmux
  import irqm_pkg::*;
#(
  parameter int ITV_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd,
  input  logic [2:0]         sel,
  input  logic [CAUSE_W-1:0] cause,
  input  logic               flag,
  input  logic [CAUSE_W-1:0] mask,
  input  logic [CAUSE_W-1:0] am,
  input  logic [ITV_W-1:0]   itv,
  output logic [31:0]        rdata
);
  logic [31:0] mux_v;

  always_comb begin
    case (sel)
      SEL_CAUSE: mux_v = {flag, cause};
      SEL_MSET:  mux_v = {1'b0, mask};
      SEL_AMASK: mux_v = {1'b0, am};
      SEL_ITV:   mux_v = 32'(itv);
      default:   mux_v = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd) rdata <= mux_v;
  end

endmodule

// File: rtl/irq_moderator.sv
module irq_moderator
  import irqm_pkg::*;
#(
  parameter int ITV_W = 16,
  parameter int TPU   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               acc_en,
  input  logic               acc_we,
  input  logic [2:0]         acc_sel,
  input  logic [31:0]        acc_wdata,
  output logic [31:0]        acc_rdata,
  input  logic               am_enable,
  input  logic               evt_valid,
  input  logic [CAUSE_W-1:0] evt_bits,
  input  logic               evt_now,
  output logic               irq
);
  logic               t_run, t_fire, t_start, t_cancel;
  logic [ITV_W-1:0]   t_units, itv_q;
  logic [CAUSE_W-1:0] cause_q, mask_q, am_q;
  logic               flag_q;
  logic               unused_hi;

  assign unused_hi = acc_wdata[31];

  irqm_core #(.ITV_W(ITV_W)) u_core (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we), .acc_sel(acc_sel),
    .wdata(acc_wdata[CAUSE_W-1:0]), .am_enable(am_enable),
    .evt_valid(evt_valid), .evt_bits(evt_bits), .evt_now(evt_now),
    .t_run(t_run), .t_fire(t_fire), .t_start(t_start), .t_cancel(t_cancel),
    .t_units(t_units), .cause_q(cause_q), .flag_q(flag_q), .mask_q(mask_q),
    .am_q(am_q), .itv_q(itv_q)
  );

  irqm_timer #(.ITV_W(ITV_W), .TPU(TPU)) u_timer (
    .clk(clk), .rst(rst), .start(t_start), .cancel(t_cancel),
    .units(t_units), .running(t_run), .fire(t_fire)
  );

  irqm_rdmux #(.ITV_W(ITV_W)) u_rd (
    .clk(clk), .rst(rst), .rd(acc_en && !acc_we), .sel(acc_sel),
    .cause(cause_q), .flag(flag_q), .mask(mask_q), .am(am_q), .itv(itv_q),
    .rdata(acc_rdata)
  );

  assign irq = flag_q;

endmodule

// File: tb/tb_irq_moderator.sv
module tb_irq_moderator;
  localparam int TPU = 32;

  logic        clk = 0;
  logic        rst = 1;
  logic        acc_en = 0, acc_we = 0;
  logic [2:0]  acc_sel = 0;
  logic [31:0] acc_wdata = 0;
  logic [31:0] acc_rdata;
  logic        am_enable = 0;
  logic        evt_valid = 0;
  logic [30:0] evt_bits = 0;
  logic        evt_now = 0;
  logic        irq;

  irq_moderator #(.ITV_W(16), .TPU(TPU)) dut (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we), .acc_sel(acc_sel),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .am_enable(am_enable),
    .evt_valid(evt_valid), .evt_bits(evt_bits), .evt_now(evt_now), .irq(irq)
  );

  always #4 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;

  // reference model state
  bit [30:0] mc, mm, mam;
  bit        mf, mrun, mstart, mcancel;
  int        mitv, mcnt;
  bit [31:0] mrd;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic m_reeval(bit iz);
    if ((mc & mm) == 0) begin
      mrun = 0; mstart = 0; mcancel = 1; mf = 0;
    end else if (iz) mf = 1;
    else if (!mrun) begin mrun = 1; mstart = 1; end
  endtask

  task automatic m_post(bit [30:0] t, bit now, bit iz);
    if (t == 0 || (t & mc) != 0) return;
    if ((mc & mm) != 0) begin
      mc |= t;
      if (!mrun) begin
        if (iz) mf = 1; else begin mrun = 1; mstart = 1; end
      end
    end else begin
      mc |= t;
      if (iz || now) begin mrun = 0; mstart = 0; mcancel = 1; mf = 1; end
      else begin mrun = 1; mstart = 1; end
    end
  endtask

  task automatic m_apply(bit en, bit we, bit [2:0] sel, bit [31:0] w,
                         bit ev, bit [30:0] eb, bit now);
    bit [30:0] w31 = w[30:0];
    mstart = 0; mcancel = 0;
    if (en && !we) begin
      case (sel)
        0: mrd = {mf, mc};
        2: mrd = {1'b0, mm};
        4: mrd = {1'b0, mam};
        5: mrd = mitv;
        default: mrd = 0;
      endcase
    end
    if (en && we) begin
      case (sel)
        0: begin if (am_enable) mm &= ~mam; mc &= ~w31; m_reeval(mitv == 0); end
        1: m_post(w31, 0, mitv == 0);
        2: begin mm |= w31; m_reeval(mitv == 0); end
        3: begin mm &= ~w31; m_reeval(mitv == 0); end
        4: mam = w31;
        5: mitv = w[15:0];
        default: ;
      endcase
    end else if (en && sel == 0) begin
      bit f0 = mf;
      if (f0 || mm == 0) mc[29:0] = 0;
      if (am_enable && f0) mm &= ~mam;
      m_reeval(mitv == 0);
    end
    if (ev) m_post(eb, now, mitv == 0);
    if (mstart) mcnt = mitv * TPU;
    else if (!mcancel && mrun) begin
      if (mcnt == 1) begin mrun = 0; mf = 1; end
      else mcnt--;
    end
  endtask

  task automatic step(string tag, bit en, bit we, bit [2:0] sel, bit [31:0] w,
                      bit ev, bit [30:0] eb, bit now);
    @(negedge clk);
    acc_en = en; acc_we = we; acc_sel = sel; acc_wdata = w;
    evt_valid = ev; evt_bits = eb; evt_now = now;
    @(posedge clk);
    #1;
    m_apply(en, we, sel, w, ev, eb, now);
    check({tag, " irq"}, {31'd0, irq}, {31'd0, mf});
    check({tag, " rdata"}, acc_rdata, mrd);
  endtask

  task automatic wr(string tag, bit [2:0] sel, bit [31:0] w);
    step(tag, 1, 1, sel, w, 0, 0, 0);
  endtask
  task automatic rd(string tag, bit [2:0] sel);
    step(tag, 1, 0, sel, 0, 0, 0, 0);
  endtask
  task automatic ev(string tag, bit [30:0] b, bit now);
    step(tag, 0, 0, 0, 0, 1, b, now);
  endtask
  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    mc = 0; mm = 0; mam = 0; mf = 0; mrun = 0; mitv = 0; mcnt = 0; mrd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    check("R1 irq after reset", {31'd0, irq}, 0);
    rd("R1", 0); check("R1 cause reads zero", acc_rdata, 0);
    rd("R1", 5); check("R1 interval reads zero", acc_rdata, 0);
    // R2 readback
    wr("R2", 5, 32'h0000_0002); rd("R2", 5); check("R2 interval", acc_rdata, 2);
    wr("R2", 4, 32'hFFFF_FFFF); rd("R2", 4); check("R2 automask", acc_rdata, 32'h7FFF_FFFF);
    wr("R2", 4, 32'h0000_0001);
    wr("R2", 5, 0);
    wr("R2", 2, 32'h0000_0001); rd("R2", 2); check("R2 mask", acc_rdata, 1);
    // R3 zero interval asserts at once
    ev("R3", 31'h1, 0); check("R3 irq at once", {31'd0, irq}, 1);
    rd("R3", 0); check("R3 cause value", acc_rdata, 32'h8000_0001);
    check("R3 deassert after ack", {31'd0, irq}, 0);
    // R5 duplicate ignored
    ev("R5", 31'h2, 0);
    ev("R5", 31'h3, 1);
    rd("R5", 0); check("R5 dup ignored", acc_rdata, 32'h8000_0002);
    // R4 throttle delay
    wr("R4", 5, 2);
    ev("R4", 31'h1, 0);
    idle("R4", 63); check("R4 not yet", {31'd0, irq}, 0);
    idle("R4", 1); check("R4 expiry", {31'd0, irq}, 1);
    rd("R4", 0);
    ev("R4", 31'h1, 1); check("R4 immediate", {31'd0, irq}, 1);
    rd("R4", 0);
    // R4 cancel via mask clear
    wr("R4", 5, 1);
    ev("R4", 31'h1, 0); idle("R4", 10);
    wr("R4", 3, 32'h1); idle("R4", 40);
    check("R4 cancelled", {31'd0, irq}, 0);
    wr("R4", 0, 32'h1);
    // R6 pending enabled keeps expiry
    wr("R6", 5, 2); wr("R6", 2, 32'h3);
    ev("R6", 31'h1, 0); idle("R6", 20);
    ev("R6", 31'h2, 1); idle("R6", 42);
    check("R6 no early rise", {31'd0, irq}, 0);
    idle("R6", 1); check("R6 first schedule", {31'd0, irq}, 1);
    rd("R6", 0);
    // R7 conditional read clear
    wr("R7", 3, 32'h2);
    ev("R7", 31'h4, 0);
    rd("R7", 0); check("R7 first", acc_rdata, 32'h0000_0004);
    rd("R7", 0); check("R7 kept", acc_rdata, 32'h0000_0004);
    wr("R7", 3, 32'hFFFF_FFFF);
    ev("R7", 31'h4000_0000, 0);
    rd("R7", 0); rd("R7", 0); check("R7 bit30 kept", acc_rdata, 32'h4000_0000);
    wr("R7", 0, 32'h4000_0000);
    // R8 auto-mask on read
    am_enable = 1;
    wr("R8", 5, 0); wr("R8", 4, 32'h1); wr("R8", 2, 32'h3);
    ev("R8", 31'h1, 0);
    rd("R8", 0); rd("R8", 2); check("R8 mask after read", acc_rdata, 2);
    // R9 cause write with auto-mask
    wr("R9", 4, 32'h2);
    ev("R9", 31'h2, 0);
    wr("R9", 0, 32'h2); check("R9 deasserted", {31'd0, irq}, 0);
    rd("R9", 2); check("R9 mask automasked", acc_rdata, 0);
    am_enable = 0;
    wr("R9", 2, 32'h3); ev("R9", 31'h1, 0);
    wr("R9", 0, 32'h1); rd("R9", 2); check("R9 mask kept", acc_rdata, 3);
    // R10 mask set/clear re-evaluation
    ev("R10", 31'h1, 0);
    wr("R10", 3, 32'h1); check("R10 clear deasserts", {31'd0, irq}, 0);
    wr("R10", 2, 32'h1); check("R10 set reasserts", {31'd0, irq}, 1);
    wr("R10", 0, 32'h1);
    // R11 set-cause write
    wr("R11", 2, 32'h8); wr("R11", 1, 32'h8);
    check("R11 posted", {31'd0, irq}, 1);
    rd("R11", 0); check("R11 value", acc_rdata, 32'h8000_0008);
    // R12 same-cycle ordering
    wr("R12", 5, 3);
    step("R12", 1, 1, 5, 0, 1, 31'h8, 0);
    check("R12 new interval used", {31'd0, irq}, 1);
    step("R12", 1, 0, 0, 0, 1, 31'h1, 0);
    check("R12 read pre-cycle value", acc_rdata, 32'h8000_0008);
    rd("R12", 0);
    idle("R12", 5);
    finish_run();
  end
endmodule